// File: doc/BRIEF.md
# Five-Stage Pipelined 32-bit Core

This block is a small in-order 32-bit processor that overlaps the work of five instructions at once. Each instruction passes through five steps in turn: fetch (the PC also advances by four), decode with register read, execute, data-memory access, and register write-back. Every instruction takes all five steps, even when some of them have nothing to do. The core runs seven instructions: add, sub, ori, lw, sw, beq and j. The control signals come from fixed AND/OR equations over the opcode and function fields. An instruction word that matches none of the seven does nothing.

Instructions and data are held in two separate internal arrays, so a fetch and a data access never compete in the same cycle. A memory-initialisation path loads both arrays, normally while reset is held. The register file is written early in a cycle and read later in that cycle, so a value being retired is seen by decode at once. Results still in flight are forwarded to the ALU. When a load is followed at once by an instruction that uses the loaded value, the pipeline waits one cycle. Wrong-path instructions after a taken branch or a jump are discarded. A debug port reads any register at any time.

Top module: `pipe5_core`

## Requirements
- R1: Opcode 000000 with function code 100000 adds and with 100010 subtracts (rd = rs op rt). Opcode 001101 ORs rs with the zero-extended 16-bit immediate into rt. Any other word, including all-zero, changes no register and no memory.
- R2: Opcode 100011 loads and opcode 101011 stores a 32-bit word at rs plus the sign-extended immediate. Address bits [1:0] are ignored and the word index wraps within the data array.
- R3: Register 0 always reads as zero, and writes to it are discarded.
- R4: A register retired in a cycle is seen by an instruction that reads it in decode during that same cycle.
- R5: An instruction gets the result of either of the two instructions just before it through forwarding. When both of them wrote the same register, the younger value wins.
- R6: When a load is followed at once by an instruction that reads its destination, the PC and the fetched word are held for one cycle and a bubble enters execute. The consumer then sees the loaded value.
- R7: Opcode 000100 compares rs and rt in execute. When they are equal, fetch continues at PC+4 plus the sign-extended offset times four, and the two younger instructions are discarded. A jump among them has no effect.
- R8: A beq whose operands differ falls through with no lost instruction results.
- R9: Opcode 000010 continues at the upper four bits of PC+4 joined with the 26-bit target times four. The one instruction fetched behind it is discarded.
- R10: Counting rising edges after reset is released, the k-th instruction (k from 0) of a stall-free program writes its register at edge 5+k. From then on, one instruction retires every cycle.
- R11: Reset clears the PC, every pipeline register (to bubbles) and every register.
- R12: With init_we high, init_data is written at word init_addr of the instruction array (init_dsel low) or of the data array (init_dsel high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_we | input | 1 | Write strobe for the initialisation path |
| init_dsel | input | 1 | 0 selects the instruction array, 1 the data array |
| init_addr | input | ADDR_W | Word index for the initialisation write |
| init_data | input | 32 | Word to write |
| dbg_addr | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Current value of the selected register |

## Verification
A taken beq in execute can fall in the same cycle as a j sitting in decode on the wrong path. The branch must win, and the jump must leave no trace. A directed program puts a j right behind a taken beq. Random programs mix beq and j freely, so the same pairing also arises by chance. Each run is judged against an instruction-by-instruction model in the bench: every register is compared once the program has reached its final self-jump, and the model takes only the branch path.

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int ADDR_W  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_we,
  input  logic              init_dsel,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [31:0]       init_data,
  input  logic [4:0]        dbg_addr,
  output logic [31:0]       dbg_data
);
  localparam int IW = 1 << IMEM_AW;
  localparam int DW = 1 << DMEM_AW;
  localparam logic [5:0] OP_RT = 6'b000000, OP_ORI = 6'b001101, OP_LW = 6'b100011,
                         OP_SW = 6'b101011, OP_BEQ = 6'b000100, OP_J = 6'b000010;
  localparam logic [5:0] FN_ADD = 6'b100000, FN_SUB = 6'b100010;

  logic [31:0] imem [IW];
  logic [31:0] dmem [DW];
  logic [31:0] rf   [32];

  logic [31:0] pc, ifid_ir, ifid_pc4;
  logic        ex_we, ex_m2r, ex_mw, ex_br, ex_src;
  logic [1:0]  ex_aluc;
  logic [4:0]  ex_rs, ex_rt, ex_rd;
  logic [31:0] ex_a, ex_b, ex_imm, ex_pc4, ex_bofs;
  logic        mm_we, mm_m2r, mm_mw;
  logic [4:0]  mm_rd;
  logic [31:0] mm_alu, mm_sd;
  logic        wb_we;
  logic [4:0]  wb_rd;
  logic [31:0] wb_val;

  // decode
  wire [5:0] op = ifid_ir[31:26];
  wire [5:0] fn = ifid_ir[5:0];
  wire [4:0] rs = ifid_ir[25:21];
  wire [4:0] rt = ifid_ir[20:16];
  wire [4:0] rd = ifid_ir[15:11];
  wire d_rt  = (op == OP_RT);
  wire d_add = d_rt && (fn == FN_ADD);
  wire d_sub = d_rt && (fn == FN_SUB);
  wire d_ori = (op == OP_ORI);
  wire d_lw  = (op == OP_LW);
  wire d_sw  = (op == OP_SW);
  wire d_beq = (op == OP_BEQ);
  wire d_j   = (op == OP_J);

  wire c_regdst = d_add | d_sub;
  wire c_src    = d_ori | d_lw | d_sw;
  wire c_rw     = d_add | d_sub | d_ori | d_lw;
  wire c_ext    = d_lw | d_sw;
  wire [1:0] c_aluc = {d_ori, d_sub | d_beq};
  wire use_rs   = d_add | d_sub | d_ori | d_lw | d_sw | d_beq;
  wire use_rt   = d_add | d_sub | d_sw | d_beq;

  wire [4:0]  id_dst = c_regdst ? rd : rt;
  wire [31:0] sext   = {{16{ifid_ir[15]}}, ifid_ir[15:0]};
  wire [31:0] id_imm = c_ext ? sext : {16'd0, ifid_ir[15:0]};
  wire [31:0] j_tgt  = {ifid_pc4[31:28], ifid_ir[25:0], 2'b00};

  function automatic logic [31:0] rdreg(input logic [4:0] a);
    if (a == 5'd0)                 return 32'd0;
    else if (wb_we && wb_rd == a)  return wb_val;
    else                           return rf[a];
  endfunction

  wire stall = ex_m2r && ex_we &&
               ((use_rs && ex_rd == rs) || (use_rt && ex_rd == rt));

  // execute
  wire [31:0] fa = (mm_we && mm_rd == ex_rs) ? mm_alu :
                   (wb_we && wb_rd == ex_rs) ? wb_val : ex_a;
  wire [31:0] fb = (mm_we && mm_rd == ex_rt) ? mm_alu :
                   (wb_we && wb_rd == ex_rt) ? wb_val : ex_b;
  wire [31:0] alu_b = ex_src ? ex_imm : fb;
  logic [31:0] alu_y;
  always_comb begin
    case (ex_aluc)
      2'b01:   alu_y = fa - alu_b;
      2'b10:   alu_y = fa | alu_b;
      default: alu_y = fa + alu_b;
    endcase
  end
  wire        br_take = ex_br && (alu_y == 32'd0);
  wire [31:0] br_tgt  = ex_pc4 + ex_bofs;
  wire        j_go    = d_j && !br_take;

  // memory
  wire [31:0] ld_val = dmem[mm_alu[DMEM_AW+1:2]];

  // fetch and decode registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ifid_ir <= '0; ifid_pc4 <= '0;
    end else if (br_take) begin
      pc <= br_tgt; ifid_ir <= '0;
    end else if (stall) begin
      pc <= pc;
    end else if (j_go) begin
      pc <= j_tgt; ifid_ir <= '0;
    end else begin
      pc <= pc + 32'd4;
      ifid_ir  <= imem[pc[IMEM_AW+1:2]];
      ifid_pc4 <= pc + 32'd4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ex_we, ex_m2r, ex_mw, ex_br, ex_src} <= '0;
      ex_aluc <= '0; ex_rs <= '0; ex_rt <= '0; ex_rd <= '0;
      ex_a <= '0; ex_b <= '0; ex_imm <= '0; ex_pc4 <= '0; ex_bofs <= '0;
    end else if (br_take || stall) begin
      {ex_we, ex_m2r, ex_mw, ex_br, ex_src} <= '0;
      ex_aluc <= '0;
    end else begin
      ex_we   <= c_rw && (id_dst != 5'd0);
      ex_m2r  <= d_lw;
      ex_mw   <= d_sw;
      ex_br   <= d_beq;
      ex_src  <= c_src;
      ex_aluc <= c_aluc;
      ex_rs   <= rs;
      ex_rt   <= rt;
      ex_rd   <= id_dst;
      ex_a    <= rdreg(rs);
      ex_b    <= rdreg(rt);
      ex_imm  <= id_imm;
      ex_pc4  <= ifid_pc4;
      ex_bofs <= {sext[29:0], 2'b00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_we <= 1'b0; mm_m2r <= 1'b0; mm_mw <= 1'b0;
      mm_rd <= '0; mm_alu <= '0; mm_sd <= '0;
      wb_we <= 1'b0; wb_rd <= '0; wb_val <= '0;
    end else begin
      mm_we  <= ex_we;
      mm_m2r <= ex_m2r;
      mm_mw  <= ex_mw;
      mm_rd  <= ex_rd;
      mm_alu <= alu_y;
      mm_sd  <= fb;
      wb_we  <= mm_we;
      wb_rd  <= mm_rd;
      wb_val <= mm_m2r ? ld_val : mm_alu;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (wb_we) begin
      rf[wb_rd] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (init_we && !init_dsel) imem[init_addr[IMEM_AW-1:0]] <= init_data;
    if (init_we && init_dsel)  dmem[init_addr[DMEM_AW-1:0]] <= init_data;
    else if (mm_mw)            dmem[mm_alu[DMEM_AW+1:2]] <= mm_sd;
  end

  assign dbg_data = rf[dbg_addr];
endmodule

module pipe5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        br_take,
  input logic        j_go,
  input logic [31:0] pc,
  input logic [31:0] br_tgt,
  input logic [31:0] j_tgt,
  input logic [31:0] ifid_ir,
  input logic        ex_we,
  input logic        ex_mw,
  input logic        ex_br,
  input logic [4:0]  dbg_addr,
  input logic [31:0] dbg_data
);
  p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_addr == 5'd0 |-> dbg_data == 32'd0);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc) && $stable(ifid_ir));
  p_stall_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_we && !ex_mw && !ex_br);
  p_branch_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(br_tgt) && ifid_ir == 32'd0 && !ex_we && !ex_mw && !ex_br);
  p_jump_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    j_go && !stall |=> pc == $past(j_tgt) && ifid_ir == 32'd0);
endmodule

bind pipe5_core pipe5_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take), .j_go(j_go),
  .pc(pc), .br_tgt(br_tgt), .j_tgt(j_tgt), .ifid_ir(ifid_ir),
  .ex_we(ex_we), .ex_mw(ex_mw), .ex_br(ex_br),
  .dbg_addr(dbg_addr), .dbg_data(dbg_data)
);

// File: tb/pipe5_core_tb_top.sv
`timescale 1ns/1ps
module pipe5_core_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_we = 1'b0, init_dsel = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic [31:0] init_data = '0;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int n_chk = 0, n_bad = 0;
  logic [31:0] prog [NW];
  logic [31:0] dinit [NW];
  logic [31:0] xrf [32];
  logic [31:0] xmem [NW];

  always #2.5 clk = ~clk;

  pipe5_core #(.IMEM_AW(AW), .DMEM_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_dsel(init_dsel),
    .init_addr(init_addr), .init_data(init_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  function automatic logic [31:0] e_r(int s, int t, int d, logic [5:0] f);
    return {6'd0, s[4:0], t[4:0], d[4:0], 5'd0, f};
  endfunction
  function automatic logic [31:0] e_i(logic [5:0] o, int s, int t, int imm);
    return {o, s[4:0], t[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] e_j(int tgt);
    return {6'b000010, tgt[25:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdbg(int r);
    return dut_i.rf[r];
  endfunction

  task automatic peek(int r, output logic [31:0] v);
    dbg_addr = r[4:0];
    #0.5;
    v = dbg_data;
  endtask

  // sequential model: runs until a jump to itself
  task automatic iss();
    int p = 0;
    for (int i = 0; i < 32; i++) xrf[i] = '0;
    for (int i = 0; i < NW; i++) xmem[i] = dinit[i];
    for (int st = 0; st < 4000; st++) begin
      logic [31:0] w, sx, a, b, ad;
      logic [4:0] s, t, d;
      w = prog[p % NW];
      s = w[25:21]; t = w[20:16]; d = w[15:11];
      sx = {{16{w[15]}}, w[15:0]};
      a = xrf[s]; b = xrf[t];
      ad = a + sx;
      if (w[31:26] == 6'b000010) begin
        if (int'(w[25:0]) == p) break;
        p = int'(w[25:0]);
        continue;
      end
      case (w[31:26])
        6'b000000: begin
          if (w[5:0] == 6'b100000 && d != 0) xrf[d] = a + b;
          if (w[5:0] == 6'b100010 && d != 0) xrf[d] = a - b;
        end
        6'b001101: if (t != 0) xrf[t] = a | {16'd0, w[15:0]};
        6'b100011: if (t != 0) xrf[t] = xmem[ad[AW+1:2]];
        6'b101011: xmem[ad[AW+1:2]] = b;
        6'b000100: if (a == b) p = p + int'(sx);
        default: ;
      endcase
      p = p + 1;
    end
  endtask

  task automatic load_and_run(int cyc);
    logic [31:0] v;
    logic [31:0] orv;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NW; i++) begin
      init_we = 1'b1; init_dsel = 1'b0; init_addr = i[AW-1:0]; init_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < NW; i++) begin
      init_we = 1'b1; init_dsel = 1'b1; init_addr = i[AW-1:0]; init_data = dinit[i];
      @(negedge clk);
    end
    init_we = 1'b0;
    orv = '0;
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      orv = orv | v;
    end
    chk("R11 registers clear in reset", orv, 32'd0);
    rst_n = 1'b1;
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cmp_regs(string tag);
    logic [31:0] v;
    iss();
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      chk($sformatf("%s r%0d", tag, r), v, xrf[r]);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < NW; i++) begin
      prog[i] = 32'd0;
      dinit[i] = 32'h1000_0000 + i * 32'h0001_0203;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'd20061));

    // R1: arithmetic, zero-extended ori, undefined words
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 1, 16'hFFFF);
    prog[1] = e_r(0, 1, 2, 6'b100010);
    prog[2] = 32'hFFFF_FFFF;
    prog[3] = e_r(1, 2, 3, 6'b100000);
    prog[4] = e_r(1, 1, 4, 6'b000111);
    prog[5] = e_j(5);
    load_and_run(40);
    cmp_regs("R1 alu");
    peek(1, v); chk("R1 ori zero-extends", v, 32'h0000_FFFF);
    peek(2, v); chk("R1 sub", v, 32'hFFFF_0001);
    peek(4, v); chk("R1 undefined funct ignored", v, 32'd0);

    // R3: register zero
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 0, 16'h55);
    prog[1] = e_r(0, 0, 1, 6'b100000);
    prog[2] = e_i(6'b100011, 0, 0, 8);
    prog[3] = e_r(0, 0, 2, 6'b100000);
    prog[4] = e_j(4);
    load_and_run(40);
    cmp_regs("R3 zero reg");
    peek(0, v); chk("R3 r0 reads zero", v, 32'd0);
    peek(2, v); chk("R3 load into r0 ignored", v, 32'd0);

    // R4: write-back and decode in the same cycle
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 1, 16'h0033);
    prog[3] = e_r(1, 0, 2, 6'b100000);
    prog[4] = e_j(4);
    load_and_run(40);
    peek(2, v); chk("R4 same-cycle write then read", v, 32'h33);

    // R5: forwarding and younger priority
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 1, 5);
    prog[1] = e_r(1, 1, 2, 6'b100000);
    prog[2] = e_r(1, 2, 3, 6'b100000);
    prog[3] = e_i(6'b001101, 0, 1, 7);
    prog[4] = e_i(6'b001101, 0, 1, 9);
    prog[5] = e_r(1, 0, 4, 6'b100000);
    prog[6] = e_j(6);
    load_and_run(40);
    cmp_regs("R5 forwarding");
    peek(4, v); chk("R5 younger result wins", v, 32'd9);

    // R2 R6 R12: loads, stores, load-use
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 1, 16'h0040);
    prog[1] = e_i(6'b001101, 0, 2, 16'h1234);
    prog[2] = e_i(6'b101011, 1, 2, -4);
    prog[3] = e_i(6'b100011, 1, 3, -4);
    prog[4] = e_r(3, 3, 4, 6'b100000);
    prog[5] = e_i(6'b100011, 0, 5, 8);
    prog[6] = e_i(6'b101011, 0, 5, 12);
    prog[7] = e_i(6'b100011, 0, 6, 12);
    prog[8] = e_j(8);
    load_and_run(50);
    cmp_regs("R2 R6 memory");
    peek(4, v); chk("R6 load-use value", v, 32'h2468);
    peek(5, v); chk("R12 data loaded by init", v, dinit[2]);
    peek(6, v); chk("R2 load after store of loaded value", v, dinit[2]);

    // R7 R8 R9: branches, jump, branch beating a wrong-path jump
    clear_prog();
    prog[0] = e_i(6'b001101, 0, 1, 3);
    prog[1] = e_i(6'b000100, 1, 0, 5);
    prog[2] = e_i(6'b000100, 1, 1, 3);
    prog[3] = e_j(9);
    prog[4] = e_i(6'b001101, 0, 5, 1);
    prog[5] = e_i(6'b001101, 0, 6, 1);
    prog[6] = e_i(6'b001101, 0, 2, 2);
    prog[7] = e_j(12);
    prog[8] = e_i(6'b001101, 0, 7, 1);
    prog[9] = e_i(6'b001101, 0, 3, 4);
    prog[12] = e_i(6'b001101, 0, 4, 8);
    prog[13] = e_j(13);
    load_and_run(60);
    cmp_regs("R7 R8 R9 control");
    peek(2, v); chk("R7 branch target reached", v, 32'd2);
    peek(3, v); chk("R7 wrong-path jump ignored", v, 32'd0);
    peek(5, v); chk("R7 younger squashed", v, 32'd0);
    peek(7, v); chk("R9 slot after jump squashed", v, 32'd0);
    peek(4, v); chk("R9 jump target reached", v, 32'd8);
    peek(1, v); chk("R8 not-taken falls through", v, 32'd3);

    // R10: latency and one retire per cycle
    clear_prog();
    for (int i = 0; i < 7; i++) prog[i] = e_i(6'b001101, 0, i + 1, 16'h100 + i);
    prog[7] = e_j(7);
    load_and_run(4);
    peek(1, v); chk("R10 r1 not yet at edge 4", v, 32'd0);
    step(1);
    peek(1, v); chk("R10 r1 at edge 5", v, 32'h100);
    step(5);
    peek(7, v); chk("R10 r7 not yet at edge 10", v, 32'd0);
    step(1);
    peek(7, v); chk("R10 r7 at edge 11", v, 32'h106);

    // random programs
    for (int pgm = 0; pgm < 40; pgm++) begin
      int n = 24;
      clear_prog();
      for (int i = 0; i < NW; i++) dinit[i] = $urandom;
      for (int i = 0; i < n; i++) begin
        int r = $urandom_range(0, 99);
        int s = $urandom_range(0, 7), t = $urandom_range(0, 7), d = $urandom_range(0, 7);
        int off = $urandom_range(0, 127) - 64;
        if (r < 20)      prog[i] = e_r(s, t, d, 6'b100000);
        else if (r < 35) prog[i] = e_r(s, t, d, 6'b100010);
        else if (r < 55) prog[i] = e_i(6'b001101, s, t, $urandom_range(0, 65535));
        else if (r < 70) prog[i] = e_i(6'b100011, s, t, off);
        else if (r < 82) prog[i] = e_i(6'b101011, s, t, off);
        else if (r < 94) begin
          int bo = $urandom_range(0, 3);
          if (i + 1 + bo > n) bo = n - i - 1;
          prog[i] = e_i(6'b000100, s, t, bo);
        end else prog[i] = e_j($urandom_range(i + 1, n));
      end
      prog[n] = e_j(n);
      load_and_run(90);
      cmp_regs($sformatf("R1 R2 R5 R6 R7 R9 random %0d", pgm));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule